// File: doc/BRIEF.md
# Buffered SPI Flash Write-Then-Read Engine

This block sits between a byte-wide host link and an SPI flash device. Bytes from the host arrive on a valid/ready receive port. The block decodes each command from that stream, and answers on a valid/ready transmit port. The main command carries a write count and a read count. The block stores the whole write payload in an internal byte buffer and then runs one SPI mode 0 transaction. During that transaction it drives chip-select itself, shifts out every stored byte, and then clocks in the requested number of bytes. A slow or stalled host link therefore never stretches the transaction on the flash side.

When the transaction ends and chip-select is high again, the block sends an acknowledge byte and then the captured bytes. The counts are checked against the buffer size before anything reaches the SPI pins. Two single-byte answers are also defined: a protocol version query, and a rejection byte for an unknown command or a count that is too large.

Top module: `flashXferEngine`

## Requirements
- R1: Command byte 0x04 starts a write-then-read. It is followed by a 16-bit write count and then a 16-bit read count, each sent high byte first, and then by exactly that many payload bytes. The payload appears on the SPI data-out pin in order, most significant bit first, in SPI mode 0: SCK idles low and each bit is valid at the rising edge.
- R2: If the write count or the read count is 4096 (BUF_DEPTH) or more, the block answers with the single byte 0x00. Chip-select never goes low for that command.
- R3: Every payload byte is accepted on the receive port before chip-select falls. While chip-select is low, the receive port is not ready.
- R4: The read phase follows the last payload byte in the same transaction. For each read byte the block sends 0xFF and captures the SPI data-in pin, most significant bit first, sampled at the rising SCK edge.
- R5: Chip-select rises after the last read byte. Only then does the transmit port offer 0x01, followed by the captured read bytes in capture order. Nothing is transmitted while chip-select is low.
- R6: A count of zero is legal. Write and read counts of 0 and 0 return only 0x01, with no chip-select activity. A zero write count gives a read-only transaction, and a zero read count returns only 0x01.
- R7: Any command byte other than 0x04 and 0x06 is answered with the single byte 0x00.
- R8: Command byte 0x06 is answered with the protocol version byte 0x01.
- R9: SCK is low whenever chip-select is high. At least one SCK period (2*CLK_DIV clock cycles) passes between chip-select falling and the first rising SCK edge. The same gap is kept between the last falling SCK edge and chip-select rising.
- R10: `busy` is low when idle. It is high from the cycle after the command byte is accepted until the last response byte is accepted on the transmit port.
- R11: While the transmit port offers a byte that is not accepted, the valid signal and the data are both held.
- R12: Read bytes may reuse the buffer locations that held the write payload. A transaction with equal write and read counts returns the bytes captured from SPI, not the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxData | input | 8 | Byte from the host |
| rxValid | input | 1 | rxData is valid |
| rxReady | output | 1 | Block accepts rxData this cycle |
| txData | output | 8 | Byte to the host |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | Host accepts txData this cycle |
| spiSck | output | 1 | SPI clock, idle low |
| spiMosi | output | 1 | SPI data to the flash |
| spiMiso | input | 1 | SPI data from the flash |
| spiCsN | output | 1 | Active-low chip-select |
| busy | output | 1 | A command is in progress |

## Verification
The hardest state to reach is the moment the shared buffer is read back after the read phase has overwritten the payload. The bench reaches it with a command whose write and read counts are equal. The flash model sends a byte stream that depends on position and is unrelated to the payload, so any leftover payload byte in the reply is visible. The chip-select guard intervals and the rule that the receive port stays closed during a transaction can only be seen from the pins. A monitor at the falling clock edge measures the gaps between the chip-select and SCK edges and counts any receive-ready cycle while chip-select is low. The hold of transmit data is driven by withholding txReady for several cycles in the middle of a reply.

// File: rtl/flashXferPkg.sv
package flashXferPkg;

  localparam int CNT_W = 16;

  localparam logic [7:0] CMD_WTR   = 8'h04;
  localparam logic [7:0] CMD_VER   = 8'h06;
  localparam logic [7:0] BYTE_OK   = 8'h01;
  localparam logic [7:0] BYTE_ERR  = 8'h00;
  localparam logic [7:0] PROTO_VER = 8'h01;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    TX_ERR,
    TX_OK,
    TX_VER,
    TX_BUF
  } txSel_e;

  typedef struct packed {
    logic   ldWHi;
    logic   ldWLo;
    logic   ldRHi;
    logic   ldRLo;
    logic   idxClr;
    logic   idxInc;
    logic   memWe;
    logic   memFromSpi;
    logic   byteStart;
    logic   shiftRead;
    logic   tmrClr;
    txSel_e txSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic lenBad;
    logic lenZero;
    logic wDone;
    logic rDone;
    logic rLast;
    logic byteDone;
    logic tmrDone;
  } dpStatus_t;

endpackage

// File: rtl/flashXferShift.sv
module flashXferShift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] loadByte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rxByte
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active;
  logic [2:0]    bitCnt;
  logic [DW-1:0] divCnt;
  logic          sckReg;
  logic [7:0]    shReg;
  logic [7:0]    inReg;
  logic          doneReg;
  logic          tick;

  assign tick = active && (divCnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      bitCnt  <= '0;
      divCnt  <= '0;
      sckReg  <= 1'b0;
      shReg   <= '0;
      inReg   <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        shReg  <= loadByte;
        divCnt <= '0;
        sckReg <= 1'b0;
        bitCnt <= '0;
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          if (!sckReg) begin
            // rising edge: sample the incoming bit
            sckReg <= 1'b1;
            inReg  <= {inReg[6:0], miso};
          end else begin
            // falling edge: present the next outgoing bit
            sckReg <= 1'b0;
            if (bitCnt == 3'd7) begin
              active  <= 1'b0;
              doneReg <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              shReg  <= {shReg[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DW'(1);
        end
      end
    end
  end

  assign sck    = sckReg;
  assign mosi   = shReg[7];
  assign done   = doneReg;
  assign rxByte = inReg;

endmodule

// File: rtl/flashXferData.sv
module flashXferData
  import flashXferPkg::*;
#(
  parameter int BUF_DEPTH = 4096,
  parameter int CLK_DIV   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t stb,
  input  logic [7:0]  rxData,
  input  logic        spiMiso,
  output dpStatus_t   st,
  output logic [7:0]  txData,
  output logic        spiSck,
  output logic        spiMosi
);

  localparam int AW    = $clog2(BUF_DEPTH);
  localparam int GUARD = 2 * CLK_DIV;
  localparam int TW    = $clog2(GUARD + 1);

  logic [CNT_W-1:0] wCnt;
  logic [CNT_W-1:0] rCnt;
  logic [CNT_W-1:0] idx;
  logic [TW-1:0]    tmr;
  logic [7:0]       mem [BUF_DEPTH];
  logic [7:0]       bufByte;
  logic [7:0]       shiftIn;
  logic [7:0]       loadByte;
  logic             byteDone;

  // length registers, loaded high byte first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wCnt <= '0;
      rCnt <= '0;
    end else begin
      if (stb.ldWHi) wCnt[15:8] <= rxData;
      if (stb.ldWLo) wCnt[7:0]  <= rxData;
      if (stb.ldRHi) rCnt[15:8] <= rxData;
      if (stb.ldRLo) rCnt[7:0]  <= rxData;
    end
  end

  // shared buffer index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idx <= '0;
    else if (stb.idxClr) idx <= '0;
    else if (stb.idxInc) idx <= idx + CNT_W'(1);
  end

  // chip-select guard timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmr <= '0;
    else if (stb.tmrClr)  tmr <= '0;
    else if (!st.tmrDone) tmr <= tmr + TW'(1);
  end

  // byte buffer: payload from the host, then read data from the flash
  always_ff @(posedge clk) begin
    if (stb.memWe) mem[idx[AW-1:0]] <= stb.memFromSpi ? shiftIn : rxData;
  end

  assign bufByte  = mem[idx[AW-1:0]];
  assign loadByte = stb.shiftRead ? FILL_BYTE : bufByte;

  flashXferShift #(.CLK_DIV(CLK_DIV)) shift_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (stb.byteStart),
    .loadByte (loadByte),
    .miso     (spiMiso),
    .sck      (spiSck),
    .mosi     (spiMosi),
    .done     (byteDone),
    .rxByte   (shiftIn)
  );

  always_comb begin
    st.lenBad   = ({{(32-CNT_W){1'b0}}, wCnt} >= 32'(BUF_DEPTH)) ||
                  ({{(32-CNT_W){1'b0}}, rCnt} >= 32'(BUF_DEPTH));
    st.lenZero  = (wCnt == '0) && (rCnt == '0);
    st.wDone    = (idx == wCnt);
    st.rDone    = (idx == rCnt);
    st.rLast    = ((idx + CNT_W'(1)) == rCnt);
    st.byteDone = byteDone;
    st.tmrDone  = (tmr == TW'(GUARD - 1));
  end

  always_comb begin
    case (stb.txSel)
      TX_OK:   txData = BYTE_OK;
      TX_VER:  txData = PROTO_VER;
      TX_BUF:  txData = bufByte;
      default: txData = BYTE_ERR;
    endcase
  end

endmodule

// File: rtl/flashXferCtrl.sv
module flashXferCtrl
  import flashXferPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  output logic        rxReady,
  output logic        txValid,
  input  logic        txReady,
  input  dpStatus_t   st,
  output ctrlStrobe_t stb,
  output logic        spiCsN,
  output logic        busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_WHI, S_WLO, S_RHI, S_RLO, S_CHECK, S_PAYLOAD, S_CSSETUP,
    S_WSTART, S_WWAIT, S_RSTART, S_RWAIT, S_CSHOLD, S_ACK, S_DATA, S_REPLY
  } state_e;

  state_e state;
  state_e nxt;
  logic   replyVer;
  logic   csNReg;

  always_comb begin
    nxt     = state;
    stb     = '0;
    rxReady = 1'b0;
    txValid = 1'b0;
    case (state)
      S_IDLE: begin
        rxReady = 1'b1;
        if (rxValid) nxt = (rxData == CMD_WTR) ? S_WHI : S_REPLY;
      end
      S_WHI: begin
        rxReady   = 1'b1;
        stb.ldWHi = rxValid;
        if (rxValid) nxt = S_WLO;
      end
      S_WLO: begin
        rxReady   = 1'b1;
        stb.ldWLo = rxValid;
        if (rxValid) nxt = S_RHI;
      end
      S_RHI: begin
        rxReady   = 1'b1;
        stb.ldRHi = rxValid;
        if (rxValid) nxt = S_RLO;
      end
      S_RLO: begin
        rxReady   = 1'b1;
        stb.ldRLo = rxValid;
        if (rxValid) nxt = S_CHECK;
      end
      S_CHECK: begin
        stb.idxClr = 1'b1;
        stb.tmrClr = 1'b1;
        if (st.lenBad)       nxt = S_REPLY;
        else if (st.lenZero) nxt = S_ACK;
        else                 nxt = S_PAYLOAD;
      end
      S_PAYLOAD: begin
        stb.tmrClr = 1'b1;
        if (st.wDone) begin
          stb.idxClr = 1'b1;
          nxt        = S_CSSETUP;
        end else begin
          rxReady    = 1'b1;
          stb.memWe  = rxValid;
          stb.idxInc = rxValid;
        end
      end
      S_CSSETUP: begin
        if (st.tmrDone) nxt = S_WSTART;
      end
      S_WSTART: begin
        stb.tmrClr = 1'b1;
        if (st.wDone) begin
          stb.idxClr = 1'b1;
          nxt        = S_RSTART;
        end else begin
          stb.byteStart = 1'b1;
          nxt           = S_WWAIT;
        end
      end
      S_WWAIT: begin
        stb.tmrClr = 1'b1;
        if (st.byteDone) begin
          stb.idxInc = 1'b1;
          nxt        = S_WSTART;
        end
      end
      S_RSTART: begin
        stb.tmrClr    = 1'b1;
        stb.shiftRead = 1'b1;
        if (st.rDone) begin
          stb.idxClr = 1'b1;
          nxt        = S_CSHOLD;
        end else begin
          stb.byteStart = 1'b1;
          nxt           = S_RWAIT;
        end
      end
      S_RWAIT: begin
        stb.tmrClr = 1'b1;
        if (st.byteDone) begin
          stb.memWe      = 1'b1;
          stb.memFromSpi = 1'b1;
          stb.idxInc     = 1'b1;
          nxt            = S_RSTART;
        end
      end
      S_CSHOLD: begin
        if (st.tmrDone) nxt = S_ACK;
      end
      S_ACK: begin
        txValid   = 1'b1;
        stb.txSel = TX_OK;
        if (txReady) nxt = st.rDone ? S_IDLE : S_DATA;
      end
      S_DATA: begin
        txValid   = 1'b1;
        stb.txSel = TX_BUF;
        if (txReady) begin
          stb.idxInc = 1'b1;
          if (st.rLast) nxt = S_IDLE;
        end
      end
      S_REPLY: begin
        txValid   = 1'b1;
        stb.txSel = replyVer ? TX_VER : TX_ERR;
        if (txReady) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      replyVer <= 1'b0;
      csNReg   <= 1'b1;
    end else begin
      state  <= nxt;
      csNReg <= !(nxt inside {S_CSSETUP, S_WSTART, S_WWAIT, S_RSTART, S_RWAIT, S_CSHOLD});
      if (state == S_IDLE && rxValid) replyVer <= (rxData == CMD_VER);
      else if (state == S_CHECK)      replyVer <= 1'b0;
    end
  end

  assign spiCsN = csNReg;
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/flashXferEngine.sv
module flashXferEngine
  import flashXferPkg::*;
#(
  parameter int BUF_DEPTH = 4096,
  parameter int CLK_DIV   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  output logic       rxReady,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  output logic       spiSck,
  output logic       spiMosi,
  input  logic       spiMiso,
  output logic       spiCsN,
  output logic       busy
);

  ctrlStrobe_t stb;
  dpStatus_t   st;

  flashXferCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rxData  (rxData),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .txValid (txValid),
    .txReady (txReady),
    .st      (st),
    .stb     (stb),
    .spiCsN  (spiCsN),
    .busy    (busy)
  );

  flashXferData #(.BUF_DEPTH(BUF_DEPTH), .CLK_DIV(CLK_DIV)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rxData  (rxData),
    .spiMiso (spiMiso),
    .st      (st),
    .txData  (txData),
    .spiSck  (spiSck),
    .spiMosi (spiMosi)
  );

endmodule

// File: rtl/flashXferChecker.sv
module flashXferChecker (
  input logic       clk,
  input logic       rstN,
  input logic       rxReady,
  input logic [7:0] txData,
  input logic       txValid,
  input logic       txReady,
  input logic       spiSck,
  input logic       spiCsN,
  input logic       busy
);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck); // R9

  AST_SCK_RISE_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSck) |-> (!spiCsN && !$past(spiCsN))); // R9

  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> !$past(spiSck)); // R9

  AST_RX_CLOSED_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> !rxReady); // R3

  AST_TX_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> !txValid); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData))); // R11

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid || !spiCsN) |-> busy); // R10

endmodule

bind flashXferEngine flashXferChecker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rxReady (rxReady),
  .txData  (txData),
  .txValid (txValid),
  .txReady (txReady),
  .spiSck  (spiSck),
  .spiCsN  (spiCsN),
  .busy    (busy)
);

// File: tb/flashXferEngine_tb_top.sv
`timescale 1ns/1ps
module flashXferEngine_tb_top;

  localparam int BUF_DEPTH = 4096;
  localparam int CLK_DIV   = 2;
  localparam int GUARD     = 2 * CLK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       rxValid = 1'b0;
  logic       rxReady;
  logic [7:0] txData;
  logic       txValid;
  logic       txReady = 1'b0;
  logic       spiSck;
  logic       spiMosi;
  logic       spiMiso;
  logic       spiCsN;
  logic       busy;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  flashXferEngine #(.BUF_DEPTH(BUF_DEPTH), .CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN), .busy(busy)
  );

  // flash model: position-dependent response stream, payload capture, edge timing
  function automatic logic [7:0] flashByte(int k);
    return 8'((k * 29 + 91) & 255);
  endfunction

  function automatic logic misoBit(int n);
    logic [7:0] v;
    v = flashByte(n / 8);
    return v[7 - (n % 8)];
  endfunction

  function automatic logic [7:0] payByte(int n, int i);
    return 8'((i * 53 + n * 7 + 1) & 255);
  endfunction

  int         sBit = 0;
  int         mosiCnt = 0;
  logic [7:0] mosiCap [64];
  logic [7:0] mAcc = 8'h00;
  int         csFalls = 0;
  int         cyc = 0;
  int         tCsFall = 0;
  int         tLastFall = 0;
  bit         firstRise = 1'b0;
  int         minLead = 1000000;
  int         minLag = 1000000;
  int         rxDuringCs = 0;
  logic       prevCs = 1'b1;
  logic       prevSck = 1'b0;

  assign spiMiso = spiCsN ? 1'b0 : misoBit(sBit);

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prevCs && !spiCsN) begin
      csFalls = csFalls + 1;
      sBit = 0;
      mosiCnt = 0;
      tCsFall = cyc;
      firstRise = 1'b1;
    end
    if (!spiCsN && !prevSck && spiSck) begin
      if (firstRise) begin
        if (cyc - tCsFall < minLead) minLead = cyc - tCsFall;
        firstRise = 1'b0;
      end
      mAcc = {mAcc[6:0], spiMosi};
      if (sBit % 8 == 7 && mosiCnt < 64) begin
        mosiCap[mosiCnt] = mAcc;
        mosiCnt = mosiCnt + 1;
      end
    end
    if (!spiCsN && prevSck && !spiSck) begin
      sBit = sBit + 1;
      tLastFall = cyc;
    end
    if (!prevCs && spiCsN) begin
      if (cyc - tLastFall < minLag) minLag = cyc - tLastFall;
    end
    if (!spiCsN && rxReady) rxDuringCs = rxDuringCs + 1;
    prevCs = spiCsN;
    prevSck = spiSck;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxData = b;
    rxValid = 1'b1;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic recvByte(input int stall, output logic [7:0] b);
    @(negedge clk);
    while (!txValid) @(negedge clk);
    b = txData;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R11 valid held", int'(txValid), 1);
      chk("R11 data held", int'(txData), int'(b));
    end
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic expectQuiet(input string tag);
    for (int k = 0; k < 6; k++) @(negedge clk);
    chk({tag, " no extra tx"}, int'(txValid), 0);
    chk("R10 busy low after reply", int'(busy), 0);
  endtask

  // full write-then-read transaction with all port-level checks
  task automatic doWtr(input int wN, input int rN, input int stall);
    logic [7:0] b;
    int csBefore;
    csBefore = csFalls;
    minLead = 1000000;
    minLag = 1000000;
    rxDuringCs = 0;
    sendByte(8'h04);
    chk("R10 busy after decode", int'(busy), 1);
    sendByte(8'((wN >> 8) & 255));
    sendByte(8'(wN & 255));
    sendByte(8'((rN >> 8) & 255));
    sendByte(8'(rN & 255));
    for (int i = 0; i < wN; i++) sendByte(payByte(wN, i));
    if (wN > 0) chk("R3 cs high until payload done", csFalls, csBefore);
    recvByte(0, b);
    chk("R5 ack byte", int'(b), 8'h01);
    chk("R5 cs high at ack", int'(spiCsN), 1);
    for (int i = 0; i < rN; i++) begin
      recvByte((i == 1) ? stall : 0, b);
      chk("R4 R5 R12 read data", int'(b), int'(flashByte(wN + i)));
    end
    chk("R10 busy low after last byte", int'(busy), 0);
    chk("R1 one cs low window", csFalls, csBefore + 1);
    chk("R1 R4 spi byte count", mosiCnt, wN + rN);
    for (int i = 0; i < wN; i++)
      chk("R1 payload on mosi", int'(mosiCap[i]), int'(payByte(wN, i)));
    for (int i = 0; i < rN; i++)
      chk("R4 fill byte on mosi", int'(mosiCap[wN + i]), 8'hFF);
    chk("R9 lead gap", int'(minLead >= GUARD), 1);
    chk("R9 lag gap", int'(minLag >= GUARD), 1);
    chk("R3 rx closed during cs", rxDuringCs, 0);
    expectQuiet("R5");
  endtask

  task automatic testReset();
    chk("R10 reset busy", int'(busy), 0);
    chk("R9 reset cs", int'(spiCsN), 1);
    chk("R9 reset sck", int'(spiSck), 0);
    chk("R5 reset txValid", int'(txValid), 0);
  endtask

  task automatic testVersion();
    logic [7:0] b;
    sendByte(8'h06);
    recvByte(0, b);
    chk("R8 version byte", int'(b), 8'h01);
    expectQuiet("R8");
  endtask

  task automatic testUnknown();
    logic [7:0] b;
    int csBefore;
    csBefore = csFalls;
    sendByte(8'h33);
    recvByte(0, b);
    chk("R7 unknown command", int'(b), 8'h00);
    chk("R7 no cs", csFalls, csBefore);
    expectQuiet("R7");
  endtask

  task automatic testOversize(input int wN, input int rN);
    logic [7:0] b;
    int csBefore;
    csBefore = csFalls;
    sendByte(8'h04);
    sendByte(8'((wN >> 8) & 255));
    sendByte(8'(wN & 255));
    sendByte(8'((rN >> 8) & 255));
    sendByte(8'(rN & 255));
    recvByte(0, b);
    chk("R2 reject byte", int'(b), 8'h00);
    chk("R2 no cs", csFalls, csBefore);
    expectQuiet("R2");
  endtask

  task automatic testZeroZero();
    logic [7:0] b;
    int csBefore;
    csBefore = csFalls;
    sendByte(8'h04);
    for (int i = 0; i < 4; i++) sendByte(8'h00);
    recvByte(0, b);
    chk("R6 zero counts ack", int'(b), 8'h01);
    chk("R6 zero counts no cs", csFalls, csBefore);
    expectQuiet("R6");
    // next byte is a fresh command
    testVersion();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testVersion();
    testUnknown();
    testOversize(4096, 1);
    testOversize(1, 4096);
    testOversize(16'hFFFF, 0);
    testZeroZero();
    doWtr(3, 2, 0);
    doWtr(0, 3, 0);   // R6 read-only
    doWtr(4, 0, 0);   // R6 write-only
    doWtr(1, 3, 5);   // R11 backpressure
    doWtr(5, 5, 0);   // R12 buffer reuse
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule